// File: doc/BRIEF.md
# Chainable Two-Channel Pulse Edge Counter

This block counts transitions on two external pulse pins with two 8-bit counters. A control bit sets how the counters are used. In split mode each counter counts edges on its own pin. In chained mode the pair forms one 16-bit counter. The low counter then counts edges on its own pin, and its carry advances the high counter.

A small register port gives software access. It can read and preload the counts at any time, either one byte at a time or as a single 16-bit word in one cycle. It also sets the edge polarity, masks the interrupt, and clears a sticky overflow flag. The flag is set whenever the high counter wraps.

The operating mode is held in a two-state machine:
- `MODE_SPLIT` is the reset state.
- `MODE_CHAINED` is the other state.
- Transition `T_FUSE` goes from `MODE_SPLIT` to `MODE_CHAINED`. It fires on a control write with bit 0 = 1.
- Transition `T_UNFUSE` goes from `MODE_CHAINED` to `MODE_SPLIT`. It fires on a control write with bit 0 = 0.
- Any other cycle holds the current state.

Top module: `pulse_acc_pair`

## Requirements
- R1: After reset, both counts are 0x00, the overflow flag is 0, `irq` is 0, and the control register reads 0x0000.
- R2: In split mode (control bit 0 = 0), the low counter counts edges on `pin_lo` and the high counter counts edges on `pin_hi`, independently. A wrap of the low counter from 0xFF to 0x00 leaves the high counter unchanged.
- R3: In chained mode (control bit 0 = 1), each counted `pin_lo` edge advances the 16-bit value {high, low} by one, carrying from the low byte into the high byte. Edges on `pin_hi` have no effect.
- R4: When the high counter wraps from 0xFF to 0x00 by counting, in either mode, the overflow flag is set. The flag reads at address 1, bit 0.
- R5: Writing a byte with bit 0 = 1 to address 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. If an overflow happens in the same cycle as a clear, the flag stays set.
- R6: `irq` is 1 exactly when the flag is 1 and the interrupt enable (control bit 2) is 1.
- R7: Control bit 1 selects the counted edge: 0 counts rising edges, 1 counts falling edges.
- R8: Byte accesses (`bus_word` = 0) use data bits [7:0]. Address 0 is control, address 2 is the high count, and address 3 is the low count. Counts can be read and written at any time.
- R9: A word access (`bus_word` = 1) at address 2 reads {high, low} on [15:0]. A word write loads [15:8] into the high counter and [7:0] into the low counter on the same edge. Word writes to any other address are ignored.
- R10: When a bus write to a counter coincides with a counted edge for that counter, the written value is kept and no carry is produced.
- R11: A pin change made between clock edges is reflected in the count after the third rising clock edge, not earlier. Each pin transition is counted at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lo | input | 1 | Pulse input of the low counter |
| pin_hi | input | 1 | Pulse input of the high counter |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, 0 when not selected) |
| cnt_hi | output | 8 | High counter value |
| cnt_lo | output | 8 | Low counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked overflow interrupt |

## Verification
A wrong mode state shows up on `cnt_hi` at the first counted low edge where the carry should or should not propagate. The same wrong state also shows on bit 0 of a control read right away.

A stuck or wrongly cleared flag appears on `ovf_flag` and `irq` one clock after the wrap or the clear write. The bench aims edges so that they land exactly on a bus write, which exposes write priority and the overflow-versus-clear race.

Synchroniser depth errors move the count update away from the third clock edge. The bench samples on both sides of that edge.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned BUS_W  = 2 * CNT_W;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd2;
    localparam logic [ADDR_W-1:0] A_LO   = 2'd3;

    localparam int unsigned B_CHAIN = 0;
    localparam int unsigned B_FALL  = 1;
    localparam int unsigned B_IRQEN = 2;

    typedef enum logic {
        MODE_SPLIT   = 1'b0,
        MODE_CHAINED = 1'b1
    } pacc_mode_e;
endpackage

// File: rtl/pacc_edge_sync.sv
module pacc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    always_comb begin
        if (fall_sel) edge_o = prev_q & ~sync_q[STAGES-1];
        else          edge_o = ~prev_q & sync_q[STAGES-1];
    end

    // R11: one transition yields a single-cycle edge pulse
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $stable(fall_sel)) |=> !edge_o);
endmodule

// File: rtl/pacc_counter8.sv
module pacc_counter8 #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic         carry
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q + 1'b1;
    end

    assign carry = inc & ~load & (q == ALL_ONES);

    // R10: a load beats a simultaneous increment
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(load_val));
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> q == $past(q) + 1'b1);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(q));
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair
    import pacc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_lo,
    input  logic              pin_hi,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  cnt_hi,
    output logic [CNT_W-1:0]  cnt_lo,
    output logic              ovf_flag,
    output logic              irq
);
    localparam int unsigned NCH = 2;

    pacc_mode_e state_q, state_d;
    logic       fall_q, irqen_q;
    logic       flag_q;

    logic [NCH-1:0] pins;
    logic [NCH-1:0] edges;

    logic wr_any, wr_ctrl, wr_flag, wr_hi, wr_lo, clr_req;
    logic [CNT_W-1:0] hi_val, lo_val;
    logic hi_inc, lo_carry, hi_carry;

    // ---------------- bus decode ----------------
    assign wr_any  = bus_sel & bus_wr;
    assign wr_ctrl = wr_any & ~bus_word & (bus_addr == A_CTRL);
    assign wr_flag = wr_any & ~bus_word & (bus_addr == A_FLAG);
    assign wr_hi   = wr_any & (bus_addr == A_HI);
    assign wr_lo   = wr_any & ((~bus_word & (bus_addr == A_LO)) |
                               (bus_word & (bus_addr == A_HI)));
    assign clr_req = wr_flag & bus_wdata[0];
    assign hi_val  = bus_word ? bus_wdata[BUS_W-1:CNT_W] : bus_wdata[CNT_W-1:0];
    assign lo_val  = bus_wdata[CNT_W-1:0];

    // ---------------- mode state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SPLIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SPLIT:   if (wr_ctrl && bus_wdata[B_CHAIN])  state_d = MODE_CHAINED; // T_FUSE
            MODE_CHAINED: if (wr_ctrl && !bus_wdata[B_CHAIN]) state_d = MODE_SPLIT;   // T_UNFUSE
            default:      state_d = MODE_SPLIT;
        endcase
    end

    // output process: count source of the high counter per state
    always_comb begin
        hi_inc = 1'b0;
        unique case (state_q)
            MODE_SPLIT:   hi_inc = edges[1];
            MODE_CHAINED: hi_inc = lo_carry;
            default:      hi_inc = 1'b0;
        endcase
    end

    // ---------------- control bits ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q  <= 1'b0;
            irqen_q <= 1'b0;
        end else if (wr_ctrl) begin
            fall_q  <= bus_wdata[B_FALL];
            irqen_q <= bus_wdata[B_IRQEN];
        end
    end

    // ---------------- input edge detection ----------------
    assign pins = {pin_hi, pin_lo};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            pacc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (pins[c]),
                .fall_sel (fall_q),
                .edge_o   (edges[c])
            );
        end
    endgenerate

    // ---------------- counters ----------------
    pacc_counter8 #(.W(CNT_W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (edges[0]),
        .load     (wr_lo),
        .load_val (lo_val),
        .q        (cnt_lo),
        .carry    (lo_carry)
    );

    pacc_counter8 #(.W(CNT_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (hi_inc),
        .load     (wr_hi),
        .load_val (hi_val),
        .q        (cnt_hi),
        .carry    (hi_carry)
    );

    // ---------------- overflow flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hi_carry) flag_q <= 1'b1;
        else if (clr_req)  flag_q <= 1'b0;
    end

    assign ovf_flag = flag_q;
    assign irq      = flag_q & irqen_q;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (bus_addr)
                A_CTRL: bus_rdata[2:0] = {irqen_q, fall_q, state_q == MODE_CHAINED};
                A_FLAG: bus_rdata[0]   = flag_q;
                A_HI:   bus_rdata      = bus_word ? {cnt_hi, cnt_lo} : {{CNT_W{1'b0}}, cnt_hi};
                A_LO:   bus_rdata      = bus_word ? '0 : {{CNT_W{1'b0}}, cnt_lo};
                default: bus_rdata     = '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_hi) == 8'hFF && cnt_hi == 8'h00 && !$past(wr_hi)) |-> ovf_flag);
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hi_carry) |=> !ovf_flag);
    a_r5_race_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && hi_carry) |=> ovf_flag);
    a_r3_hi_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_CHAINED && !lo_carry && !wr_hi) |=> $stable(cnt_hi));
    a_r2_split_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_SPLIT && !edges[1] && !wr_hi) |=> $stable(cnt_hi));
    a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irqen_q |-> !irq);
endmodule

// File: tb/pulse_acc_pair_tb_top.sv
module pulse_acc_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_lo = 1'b0, pin_hi = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [7:0]  cnt_hi, cnt_lo;
    logic        ovf_flag, irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pulse_acc_pair dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lo(pin_lo), .pin_hi(pin_hi),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic        word;
        logic [1:0]  addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 2'd3, 16'h00A5, 4'd8},
        '{1'b0, 1'b0, 2'd3, 16'h00A5, 4'd8},
        '{1'b1, 1'b0, 2'd2, 16'h003C, 4'd8},
        '{1'b0, 1'b0, 2'd2, 16'h003C, 4'd8},
        '{1'b0, 1'b1, 2'd2, 16'h3CA5, 4'd9},
        '{1'b1, 1'b1, 2'd2, 16'hBEEF, 4'd9},
        '{1'b0, 1'b0, 2'd2, 16'h00BE, 4'd9},
        '{1'b0, 1'b0, 2'd3, 16'h00EF, 4'd9},
        '{1'b1, 1'b0, 2'd0, 16'h0006, 4'd8},
        '{1'b0, 1'b0, 2'd0, 16'h0006, 4'd8},
        '{1'b1, 1'b0, 2'd0, 16'h0000, 4'd8},
        '{1'b0, 1'b0, 2'd0, 16'h0000, 4'd8},
        '{1'b1, 1'b1, 2'd3, 16'h1234, 4'd9},
        '{1'b0, 1'b1, 2'd2, 16'hBEEF, 4'd9}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic word, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
    endtask

    task automatic bus_read(input logic word, input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_word = 1'b0;
    endtask

    task automatic pulse(input bit hi);
        @(negedge clk);
        if (hi) pin_hi = 1'b1; else pin_lo = 1'b1;
        repeat (4) @(negedge clk);
        if (hi) pin_hi = 1'b0; else pin_lo = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // pin_lo rises, and the bus write lands on the edge where that rise is counted
    task automatic edge_with_write(input logic word, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        pin_lo = 1'b1;
        repeat (2) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
        repeat (3) @(negedge clk);
        pin_lo = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        #500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cnt", {cnt_hi, cnt_lo}, 16'h0000);
        check("R1 flag/irq", {14'd0, ovf_flag, irq}, 16'h0000);
        bus_read(1'b0, 2'd0, rd); check("R1 ctrl", rd, 16'h0000);

        // register vector table (R8, R9)
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) bus_write(VECS[i].word, VECS[i].addr, VECS[i].data);
            else begin
                bus_read(VECS[i].word, VECS[i].addr, rd);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].data);
            end
        end

        // R2 split counting
        bus_write(1'b1, 2'd2, 16'h0000);
        repeat (3) pulse(1'b0);
        repeat (2) pulse(1'b1);
        check("R2 independent", {cnt_hi, cnt_lo}, 16'h0203);
        bus_write(1'b0, 2'd3, 16'h00FF);
        pulse(1'b0);
        check("R2 no carry", {cnt_hi, cnt_lo}, 16'h0200);

        // R3 chained mode
        bus_write(1'b0, 2'd0, 16'h0001);
        bus_read(1'b0, 2'd0, rd); check("R3 mode bit", rd, 16'h0001);
        bus_write(1'b1, 2'd2, 16'h12FF);
        pulse(1'b0);
        check("R3 carry", {cnt_hi, cnt_lo}, 16'h1300);
        pulse(1'b1);
        check("R3 hi pin ignored", {cnt_hi, cnt_lo}, 16'h1300);

        // R4 overflow, R6 irq, R5 clear
        bus_write(1'b1, 2'd2, 16'hFFFF);
        pulse(1'b0);
        check("R4 wrap", {cnt_hi, cnt_lo}, 16'h0000);
        bus_read(1'b0, 2'd1, rd); check("R4 flag", rd, 16'h0001);
        check("R6 masked", {15'd0, irq}, 16'h0000);
        bus_write(1'b0, 2'd0, 16'h0005);
        check("R6 irq on", {15'd0, irq}, 16'h0001);
        bus_write(1'b0, 2'd1, 16'h0000);
        check("R5 write0 keeps", {15'd0, ovf_flag}, 16'h0001);
        bus_write(1'b0, 2'd1, 16'h0001);
        check("R5 clear", {15'd0, ovf_flag}, 16'h0000);
        check("R6 irq off", {15'd0, irq}, 16'h0000);

        // R5 overflow and clear in the same cycle
        bus_write(1'b1, 2'd2, 16'hFFFF);
        edge_with_write(1'b0, 2'd1, 16'h0001);
        check("R5 race flag", {15'd0, ovf_flag}, 16'h0001);
        check("R5 race cnt", {cnt_hi, cnt_lo}, 16'h0000);
        bus_write(1'b0, 2'd1, 16'h0001);

        // R10 write beats coincident edge, no carry
        bus_write(1'b1, 2'd2, 16'h05FF);
        edge_with_write(1'b0, 2'd3, 16'h0040);
        check("R10 write wins", {cnt_hi, cnt_lo}, 16'h0540);
        check("R10 no flag", {15'd0, ovf_flag}, 16'h0000);

        // R7 falling-edge polarity in split mode
        bus_write(1'b0, 2'd0, 16'h0002);
        bus_write(1'b1, 2'd2, 16'h0000);
        @(negedge clk); pin_lo = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 rise ignored", {cnt_hi, cnt_lo}, 16'h0000);
        pin_lo = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 fall counted", {cnt_hi, cnt_lo}, 16'h0001);

        // R4 overflow in split mode
        bus_write(1'b0, 2'd0, 16'h0000);
        bus_write(1'b1, 2'd2, 16'hFF00);
        pulse(1'b1);
        check("R4 split wrap", {cnt_hi, cnt_lo}, 16'h0000);
        check("R4 split flag", {15'd0, ovf_flag}, 16'h0001);

        // R11 latency: count appears after the third edge
        bus_write(1'b1, 2'd2, 16'h0000);
        @(negedge clk); pin_lo = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 not early", {8'd0, cnt_lo}, 16'h0000);
        @(negedge clk);
        check("R11 on time", {8'd0, cnt_lo}, 16'h0001);
        repeat (5) @(negedge clk);
        check("R11 once", {8'd0, cnt_lo}, 16'h0001);
        pin_lo = 1'b0;
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule